// File: doc/BRIEF.md
# Two-Lane Unfolded Biquad Filter

This block is a second-order recursive (IIR) filter that handles two samples in every clock iteration. The single-rate recursion has been unfolded by a factor of two. Two copies of the direct-form difference equation run side by side. Each unit delay of the single-rate graph becomes a wire from the earlier lane to the later lane inside one iteration, plus a register from the later lane back to the earlier lane between iterations. The recursion therefore crosses from lane 0 into lane 1 combinationally, and from lane 1 back into lane 0 through the state registers.

A source presents a pair of consecutive samples on the two input lanes and raises `in_valid`. The filtered pair appears on the two output lanes with `out_valid` a fixed two registers later. The feed-forward taps sit in a first pipeline stage. The feedback taps and the recursion state sit in a second stage. The coefficients are fixed parameters in signed Q2.14 form. The output stream is bit-identical to that of a single-rate filter with the same arithmetic fed the same samples one at a time.

Top module: `biquad2_unfold`

## Requirements
- R1: Each accepted pair is two consecutive samples of one stream, with `in_l0` the earlier and `in_l1` the later. `out_l0` and `out_l1` carry the filter outputs for those same two time steps, in the same order.
- R2: Every output equals y[n] = B0·x[n] + B1·x[n-1] + B2·x[n-2] + F1·y[n-1] + F2·y[n-2]. Each product is the full signed product shifted right arithmetically by 14 bits and cut to 16 bits. The five 16-bit terms are summed modulo 2^16 into a signed 16-bit result.
- R3: A pair accepted on rising edge k is presented with `out_valid` high after edge k+1. `out_valid` is low in every cycle whose edge two clocks earlier did not accept a pair.
- R4: Cycles with `in_valid` low leave the filter state and the output lanes unchanged. A stream with idle gaps therefore yields the same outputs as the same stream sent without gaps.
- R5: Synchronous active-high `rst` clears `out_valid`, both output lanes and all input and output history. After reset the filter behaves as if every earlier sample were zero.
- R6: Truncation rounds toward minus infinity, so a small negative product gives -1 rather than 0. Full-scale inputs of +32767 and -32768 follow R2 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The input pair is taken on this edge |
| in_l0 | input | 16 | Earlier sample of the pair, signed |
| in_l1 | input | 16 | Later sample of the pair, signed |
| out_valid | output | 1 | The output lanes carry a new pair |
| out_l0 | output | 16 | Filter output for the earlier time step |
| out_l1 | output | 16 | Filter output for the later time step |

## Verification
The assertions assume that `in_valid` is a clean 0 or 1 at every sampled edge and that a pair is new exactly when `in_valid` is high. They also assume that `rst` is held for at least one edge before any pair is sent. The bench drives its inputs only on falling edges. It holds `in_valid` low throughout every reset, and it runs both back-to-back streams and streams spaced by idle cycles, so the two-cycle latency property is exercised with and without gaps.

// File: rtl/biquad2_pkg.sv
package biquad2_pkg;

    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 16;
    localparam int Q_FRAC   = 14;
    localparam int PROD_W   = SAMPLE_W + COEF_W;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [COEF_W-1:0]   coef_t;
    typedef logic signed [PROD_W-1:0]   prod_t;

    // earlier time step in 'early', later one in 'late'
    typedef struct packed {
        sample_t late;
        sample_t early;
    } pair_t;

    // fixed-point multiply: full product, arithmetic shift, cut to sample width
    function automatic sample_t q_mul(sample_t v, coef_t c);
        prod_t full;
        full = PROD_W'(v) * PROD_W'(c);
        return sample_t'(full >>> Q_FRAC);
    endfunction

    // modular three-term sum
    function automatic sample_t wsum3(sample_t a, sample_t b, sample_t c);
        return a + b + c;
    endfunction

endpackage

// File: rtl/biquad2_ff.sv
module biquad2_ff
    import biquad2_pkg::*;
#(
    parameter coef_t B0 = 16'sd2048,
    parameter coef_t B1 = 16'sd4096,
    parameter coef_t B2 = 16'sd2048
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  pair_t x_in,
    output logic  ff_valid,
    output pair_t ff_out
);

    // hist_q.late = x[2k-1], hist_q.early = x[2k-2]
    pair_t hist_q;
    pair_t ff_d;

    always_comb begin
        ff_d.early = wsum3(q_mul(x_in.early, B0),
                           q_mul(hist_q.late, B1),
                           q_mul(hist_q.early, B2));
        ff_d.late  = wsum3(q_mul(x_in.late, B0),
                           q_mul(x_in.early, B1),
                           q_mul(hist_q.late, B2));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q   <= '0;
            ff_out   <= '0;
            ff_valid <= 1'b0;
        end else begin
            ff_valid <= in_valid;
            if (in_valid) begin
                hist_q <= x_in;
                ff_out <= ff_d;
            end
        end
    end

    // R4
    ff_hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(hist_q));

endmodule

// File: rtl/biquad2_fb.sv
module biquad2_fb
    import biquad2_pkg::*;
#(
    parameter coef_t F1 = 16'sd14746,
    parameter coef_t F2 = -16'sd8192
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  ff_valid,
    input  pair_t ff_in,
    output logic  y_valid,
    output pair_t y_out
);

    // y_q.late = y[2k-1], y_q.early = y[2k-2]
    pair_t y_q;
    pair_t y_d;

    always_comb begin
        // earlier lane closes the loop through the registers
        y_d.early = wsum3(ff_in.early,
                          q_mul(y_q.late, F1),
                          q_mul(y_q.early, F2));
        // later lane takes the earlier lane's result within the iteration
        y_d.late  = wsum3(ff_in.late,
                          q_mul(y_d.early, F1),
                          q_mul(y_q.late, F2));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            y_q     <= '0;
            y_valid <= 1'b0;
        end else begin
            y_valid <= ff_valid;
            if (ff_valid) y_q <= y_d;
        end
    end

    assign y_out = y_q;

    // R4
    fb_state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ff_valid |=> $stable(y_q));

endmodule

// File: rtl/biquad2_unfold.sv
module biquad2_unfold
    import biquad2_pkg::*;
#(
    parameter coef_t B0 = 16'sd2048,
    parameter coef_t B1 = 16'sd4096,
    parameter coef_t B2 = 16'sd2048,
    parameter coef_t F1 = 16'sd14746,
    parameter coef_t F2 = -16'sd8192
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_l0,
    input  logic signed [SAMPLE_W-1:0] in_l1,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_l0,
    output logic signed [SAMPLE_W-1:0] out_l1
);

    pair_t x_pair;
    pair_t ff_pair;
    pair_t y_pair;
    logic  ff_valid;

    assign x_pair.early = in_l0;
    assign x_pair.late  = in_l1;

    biquad2_ff #(.B0(B0), .B1(B1), .B2(B2)) u_ff (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .x_in     (x_pair),
        .ff_valid (ff_valid),
        .ff_out   (ff_pair)
    );

    biquad2_fb #(.F1(F1), .F2(F2)) u_fb (
        .clk      (clk),
        .rst      (rst),
        .ff_valid (ff_valid),
        .ff_in    (ff_pair),
        .y_valid  (out_valid),
        .y_out    (y_pair)
    );

    assign out_l0 = y_pair.early;
    assign out_l1 = y_pair.late;

    // R3
    lat_two_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    // R3
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    // R5
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_l0 == '0 && out_l1 == '0));

endmodule

// File: tb/sim_biquad2_unfold.sv
module sim_biquad2_unfold;

    localparam int NP = 12;
    localparam int KB0 = 2048, KB1 = 4096, KB2 = 2048, KF1 = 14746, KF2 = -8192;

    localparam logic signed [15:0] STIM [0:2*NP-1] = '{
        16'sd1000,  16'sd0,     16'sd0,     16'sd0,
        -16'sd3000, 16'sd2500,  16'sd7000,  -16'sd7000,
        16'sd123,   -16'sd1,    16'sd32767, 16'sd32767,
        -16'sd32768, -16'sd32768, 16'sd0,   16'sd500,
        16'sd4096,  16'sd4096,  -16'sd17,   16'sd19,
        16'sd0,     16'sd0,     16'sd8191,  -16'sd8191
    };

    logic clk = 1'b0;
    logic rst;
    logic in_valid;
    logic signed [15:0] in_l0, in_l1;
    logic out_valid;
    logic signed [15:0] out_l0, out_l1;

    int checks = 0;
    int errors = 0;
    int rx1, rx2, ry1, ry2;
    int e0 [NP];
    int e1 [NP];

    always #5 clk = ~clk;

    biquad2_unfold u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_l0(in_l0), .in_l1(in_l1),
        .out_valid(out_valid), .out_l0(out_l0), .out_l1(out_l1)
    );

    function automatic int wrap16(longint v);
        logic [15:0] t;
        t = v[15:0];
        return int'($signed(t));
    endfunction

    function automatic int bmul(int c, int a);
        longint p;
        p = longint'(c) * longint'(a);
        p = p >>> 14;
        return wrap16(p);
    endfunction

    task automatic ref_clear();
        rx1 = 0; rx2 = 0; ry1 = 0; ry2 = 0;
    endtask

    task automatic ref_step(input int x, output int y);
        longint s;
        s = longint'(bmul(KB0, x)) + bmul(KB1, rx1) + bmul(KB2, rx2)
          + bmul(KF1, ry1) + bmul(KF2, ry2);
        y = wrap16(s);
        rx2 = rx1; rx1 = x;
        ry2 = ry1; ry1 = y;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        chk("R5 valid", int'(out_valid), 0);
        chk("R5 lane0", int'(out_l0), 0);
        chk("R5 lane1", int'(out_l1), 0);
        rst = 1'b0;
        ref_clear();
    endtask

    // starts and ends on a falling edge; one pair with idle cycles after it
    task automatic send_gap(input string req, input int a, input int b);
        int ya, yb;
        ref_step(a, ya);
        ref_step(b, yb);
        in_valid = 1'b1; in_l0 = 16'(a); in_l1 = 16'(b);
        @(negedge clk);
        in_valid = 1'b0; in_l0 = 16'sd0; in_l1 = 16'sd0;
        @(negedge clk);
        chk({req, " valid"}, int'(out_valid), 1);
        chk({req, " lane0"}, int'(out_l0), ya);
        chk({req, " lane1"}, int'(out_l1), yb);
        repeat (2) begin
            @(negedge clk);
            chk("R4 idle valid", int'(out_valid), 0);
            chk("R4 idle lane0", int'(out_l0), ya);
            chk("R4 idle lane1", int'(out_l1), yb);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_l0 = '0; in_l1 = '0;
        repeat (3) @(negedge clk);
        chk("R5 valid", int'(out_valid), 0);
        chk("R5 lane0", int'(out_l0), 0);
        chk("R5 lane1", int'(out_l1), 0);
        rst = 1'b0;
        ref_clear();

        // table walk: back-to-back pairs, R1 R2 R3
        for (int i = 0; i < NP; i++) begin
            ref_step(int'(STIM[2*i]), e0[i]);
            ref_step(int'(STIM[2*i+1]), e1[i]);
        end
        for (int m = 0; m < NP + 2; m++) begin
            @(negedge clk);
            if (m >= 2) begin
                chk("R3 valid", int'(out_valid), 1);
                chk("R1 lane0", int'(out_l0), e0[m-2]);
                chk("R2 lane1", int'(out_l1), e1[m-2]);
            end
            if (m < NP) begin
                in_valid = 1'b1; in_l0 = STIM[2*m]; in_l1 = STIM[2*m+1];
            end else begin
                in_valid = 1'b0; in_l0 = '0; in_l1 = '0;
            end
        end
        @(negedge clk);
        chk("R3 drop", int'(out_valid), 0);
        chk("R4 hold lane1", int'(out_l1), e1[NP-1]);

        // impulse in lane 0 with gaps, R4 R2
        do_reset();
        send_gap("R2 imp", 16384, 0);
        for (int k = 0; k < 4; k++) send_gap("R4 gap", 0, 0);
        // same stream mixed back-to-back vs gapped continues consistently
        send_gap("R4 gap", 300, -200);

        // impulse in lane 1 crosses back to lane 0
        do_reset();
        send_gap("R1 imp", 0, 16384);
        send_gap("R1 imp", 0, 0);

        // negative truncation and full scale, R6
        do_reset();
        send_gap("R6 neg", -1, -1);
        send_gap("R6 full", 32767, -32768);
        send_gap("R6 full", -32768, -32768);

        // reset mid-stream clears history, R5
        send_gap("R2 pre", 9000, 9000);
        do_reset();
        send_gap("R5 after", 0, 0);
        chk("R5 zero lane0", int'(out_l0), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule